// File: doc/BRIEF.md
# Miss-Buffer Blocking Controller

This block sits beside a non-blocking cache and decides when the processor-side request port must stall. It keeps an occupancy count for two allocation queues, one holding outstanding misses and one holding writes and writebacks on their way to memory. It also holds a third stall reason, raised and dropped by the cache when an outstanding miss entry has no room left for further targets. Each reason owns one bit of a blocked mask, and the port stalls while any bit is set.

Every allocation gets an order number from a running counter. The block forms the entry's address and size: a cacheable miss is widened to a whole cache block, while other kinds keep what they were given. On request, the allocation also raises a memory-side bus request tagged with the queue it went into. For performance analysis, the block counts how often each reason started a stall. It also charges the length of each stall episode to the reason whose release ended it.

Top module: `mbuf_block_ctrl`

## Requirements
- R1: A synchronous reset clears the blocked mask, the stall, both queue occupancies, the order counter and all event and cycle counters. The first allocation after reset gets order 0.
- R2: `alloc_kind` encoding: 0 is a cacheable miss, 1 is an uncached read, and 2 or 3 is a write. The entry appears on the `ent_*` outputs one cycle after `alloc_valid`. A cacheable miss goes to queue 0 with its address low log2(BLK_BYTES) bits cleared and size BLK_BYTES. An uncached read goes to queue 0 and a write goes to queue 1, both with the exact address and size.
- R3: Order numbers start at 0 and rise by one with each allocation.
- R4: One cycle after an allocation with `alloc_bus_req` high, `bus_req` is high and `bus_req_cause` holds the queue index (0 miss, 1 write). `bus_req` stays low in every other cycle.
- R5: An allocation that makes its queue hold its full depth sets mask bit 0 (miss queue) or bit 1 (write queue), visible the next cycle. Earlier allocations leave the bit clear.
- R6: A service strobe clears the queue's bit only when the queue was full before the strobe and is not full after it. A service strobe on a queue that is not full leaves the mask unchanged.
- R7: `tgt_set` sets mask bit 2 and `tgt_clr` clears it. If both are high in the same cycle, the bit ends up set.
- R8: `cpu_stall` is high exactly in the cycles where the mask is non-zero. It rises the cycle after the mask leaves zero and falls the cycle after it returns to zero.
- R9: When the mask leaves zero, the event counter of the lowest-indexed newly set cause increases by one. Causes set while the mask is already non-zero count nothing.
- R10: When the mask returns to zero, the number of cycles `cpu_stall` was high is added to the cycle counter of the cause whose clear emptied it. If several clear together, the lowest-indexed one is charged. Other counters are unchanged.
- R11: Setting a cause that is already set, or clearing one that is already clear, changes no counter and causes no stall transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | Allocation strobe |
| alloc_kind | input | 2 | 0 cacheable miss, 1 uncached read, 2/3 write |
| alloc_addr | input | AW | Request address |
| alloc_size | input | SW | Request size in bytes |
| alloc_bus_req | input | 1 | Raise a memory-side bus request for this allocation |
| mq_service | input | 1 | A miss-queue entry is marked in service |
| wb_service | input | 1 | A write-queue entry is marked in service |
| tgt_set | input | 1 | Raise the no-free-targets cause |
| tgt_clr | input | 1 | Drop the no-free-targets cause |
| ent_valid | output | 1 | Entry outputs valid |
| ent_queue | output | 1 | Queue index of the entry |
| ent_addr | output | AW | Entry address |
| ent_size | output | SW | Entry size |
| ent_order | output | OW | Entry order number |
| bus_req | output | 1 | Memory-side bus request |
| bus_req_cause | output | 1 | Queue index tagging the bus request |
| cpu_stall | output | 1 | Processor-side port stall |
| blk_mask | output | 3 | Blocked mask: bit 0 miss queue full, bit 1 write queue full, bit 2 no free targets |
| blk_events | output | 3*CW | Per-cause stall-start counters, cause c at bits c*CW upward |
| blk_cycles | output | 3*CW | Per-cause blocked-cycle counters, cause c at bits c*CW upward |

## Verification
The assertions assume the cache never allocates into a full queue unless it services that queue in the same cycle. They also assume it never services an empty queue. Given those, mask bits 0 and 1 mirror the queue-full state. The stimulus keeps a running occupancy of each queue and issues strobes only within those limits. It drives the full and non-full service cases, simultaneous set and clear of several causes, and redundant strobes.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
   localparam int NCAUSE = 3;
   localparam int NQUEUE = 2;

   typedef enum logic [1:0] {
      CAUSE_MISSQ = 2'd0,
      CAUSE_WBUF  = 2'd1,
      CAUSE_TGT   = 2'd2
   } cause_e;

   typedef enum logic [1:0] {
      KIND_MISS   = 2'd0,
      KIND_UNC_RD = 2'd1,
      KIND_WRITE  = 2'd2,
      KIND_WRITE2 = 2'd3
   } kind_e;

   // queue selection: the upper kind bit picks the write queue
   function automatic logic kind_queue(input logic [1:0] k);
      return k[1];
   endfunction
endpackage

// File: rtl/mbc_queue_occ.sv
module mbc_queue_occ #(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic alloc,
   input  logic svc,
   output logic full,
   output logic cause_set,
   output logic cause_clr
);
   localparam int OCW = $clog2(DEPTH + 1);
   localparam logic [OCW-1:0] LIMIT = OCW'(DEPTH);

   logic [OCW-1:0] occ_q, occ_n;
   logic           was_full, now_full;

   always_comb begin
      occ_n = occ_q;
      if (alloc && !svc)      occ_n = occ_q + OCW'(1);
      else if (svc && !alloc) occ_n = occ_q - OCW'(1);
      was_full  = (occ_q == LIMIT);
      now_full  = (occ_n == LIMIT);
      cause_set = alloc && now_full;
      cause_clr = svc && was_full && !now_full;
      full      = was_full;
   end

   always_ff @(posedge clk) begin
      if (rst) occ_q <= '0;
      else     occ_q <= occ_n;
   end

   // R5
   occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
      occ_q <= LIMIT);
   // R5
   no_alloc_full_chk: assert property (@(posedge clk) disable iff (rst)
      !(alloc && !svc && was_full));
   // R6
   no_svc_empty_chk: assert property (@(posedge clk) disable iff (rst)
      !(svc && !alloc && occ_q == '0));
endmodule

// File: rtl/mbc_alloc_path.sv
module mbc_alloc_path
   import mbc_pkg::*;
#(
   parameter int AW        = 32,
   parameter int SW        = 8,
   parameter int OW        = 16,
   parameter int BLK_BYTES = 64
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          alloc_valid,
   input  logic [1:0]    alloc_kind,
   input  logic [AW-1:0] alloc_addr,
   input  logic [SW-1:0] alloc_size,
   input  logic          alloc_bus_req,
   output logic          ent_valid,
   output logic          ent_queue,
   output logic [AW-1:0] ent_addr,
   output logic [SW-1:0] ent_size,
   output logic [OW-1:0] ent_order,
   output logic          breq_valid,
   output logic          breq_cause
);
   localparam int OFFW = $clog2(BLK_BYTES);
   localparam logic [SW-1:0] BLK_SIZE = SW'(BLK_BYTES);

   logic [AW-1:0] aligned;
   logic          cacheable;
   logic          ent_cach_q;
   logic [OW-1:0] order_q;

   assign cacheable = (alloc_kind == KIND_MISS);

   generate
      if (OFFW == 0) begin : g_noalign
         assign aligned = alloc_addr;
      end else begin : g_align
         assign aligned = {alloc_addr[AW-1:OFFW], {OFFW{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         ent_valid  <= 1'b0;
         ent_queue  <= 1'b0;
         ent_addr   <= '0;
         ent_size   <= '0;
         ent_order  <= '0;
         ent_cach_q <= 1'b0;
         order_q    <= '0;
         breq_valid <= 1'b0;
         breq_cause <= 1'b0;
      end else begin
         ent_valid  <= alloc_valid;
         breq_valid <= alloc_valid && alloc_bus_req;
         if (alloc_valid) begin
            ent_queue  <= kind_queue(alloc_kind);
            breq_cause <= kind_queue(alloc_kind);
            ent_addr   <= cacheable ? aligned : alloc_addr;
            ent_size   <= cacheable ? BLK_SIZE : alloc_size;
            ent_cach_q <= cacheable;
            ent_order  <= order_q;
            order_q    <= order_q + OW'(1);
         end
      end
   end

   generate
      if (OFFW > 0) begin : g_align_chk
         // R2
         aligned_chk: assert property (@(posedge clk) disable iff (rst)
            (ent_valid && ent_cach_q) |-> (ent_addr[OFFW-1:0] == '0 && ent_size == BLK_SIZE));
      end
   endgenerate

   // R3
   order_step_chk: assert property (@(posedge clk) disable iff (rst)
      ent_valid |-> (ent_order == order_q - OW'(1)));
   // R4
   breq_with_entry_chk: assert property (@(posedge clk) disable iff (rst)
      breq_valid |-> (ent_valid && breq_cause == ent_queue));
endmodule

// File: rtl/mbc_block_mask.sv
module mbc_block_mask #(
   parameter int NC = 3,
   parameter int CW = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NC-1:0]    set_v,
   input  logic [NC-1:0]    clr_v,
   output logic [NC-1:0]    mask_q,
   output logic             stall_q,
   output logic [NC*CW-1:0] ev_flat,
   output logic [NC*CW-1:0] cyc_flat
);
   logic [NC-1:0] mask_n, freed, rise_one, fall_one;
   logic          rise, fall;
   logic [CW-1:0] tick_q, start_q, span;

   always_comb begin
      mask_n   = (mask_q & ~clr_v) | set_v;
      rise     = (mask_q == '0) && (mask_n != '0);
      fall     = (mask_q != '0) && (mask_n == '0);
      freed    = mask_q & clr_v;
      rise_one = mask_n & (~mask_n + NC'(1));
      fall_one = freed & (~freed + NC'(1));
      span     = tick_q - start_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mask_q  <= '0;
         stall_q <= 1'b0;
         tick_q  <= '0;
         start_q <= '0;
      end else begin
         mask_q <= mask_n;
         tick_q <= tick_q + CW'(1);
         if (rise) begin
            stall_q <= 1'b1;
            start_q <= tick_q;
         end else if (fall) begin
            stall_q <= 1'b0;
         end
      end
   end

   generate
      for (genvar c = 0; c < NC; c++) begin : g_cause
         logic [CW-1:0] ev_q, cy_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               ev_q <= '0;
               cy_q <= '0;
            end else begin
               if (rise && rise_one[c]) ev_q <= ev_q + CW'(1);
               if (fall && fall_one[c]) cy_q <= cy_q + span;
            end
         end
         assign ev_flat[c*CW +: CW]  = ev_q;
         assign cyc_flat[c*CW +: CW] = cy_q;
      end
   endgenerate

   // R8
   stall_tracks_mask_chk: assert property (@(posedge clk) disable iff (rst)
      stall_q == (mask_q != '0));
   // R9
   event_only_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (mask_q != '0) |=> $stable(ev_flat));
   // R10
   cycles_only_on_release_chk: assert property (@(posedge clk) disable iff (rst)
      (mask_q == '0) |=> $stable(cyc_flat));
endmodule

// File: rtl/mbuf_block_ctrl.sv
module mbuf_block_ctrl
   import mbc_pkg::*;
#(
   parameter int AW        = 32,
   parameter int SW        = 8,
   parameter int OW        = 16,
   parameter int CW        = 32,
   parameter int BLK_BYTES = 64,
   parameter int DEPTH_MQ  = 4,
   parameter int DEPTH_WB  = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 alloc_valid,
   input  logic [1:0]           alloc_kind,
   input  logic [AW-1:0]        alloc_addr,
   input  logic [SW-1:0]        alloc_size,
   input  logic                 alloc_bus_req,
   input  logic                 mq_service,
   input  logic                 wb_service,
   input  logic                 tgt_set,
   input  logic                 tgt_clr,
   output logic                 ent_valid,
   output logic                 ent_queue,
   output logic [AW-1:0]        ent_addr,
   output logic [SW-1:0]        ent_size,
   output logic [OW-1:0]        ent_order,
   output logic                 bus_req,
   output logic                 bus_req_cause,
   output logic                 cpu_stall,
   output logic [NCAUSE-1:0]    blk_mask,
   output logic [NCAUSE*CW-1:0] blk_events,
   output logic [NCAUSE*CW-1:0] blk_cycles
);
   generate
      if (BLK_BYTES < 1 || (BLK_BYTES & (BLK_BYTES - 1)) != 0) begin : g_bad_blk
         $error("BLK_BYTES must be a power of two");
      end
      if (BLK_BYTES >= (1 << SW)) begin : g_bad_sw
         $error("SW too narrow to hold BLK_BYTES");
      end
      if (DEPTH_MQ < 1 || DEPTH_WB < 1) begin : g_bad_depth
         $error("queue depths must be at least one");
      end
      if (BLK_BYTES > (1 << (AW - 1))) begin : g_bad_aw
         $error("AW too narrow for BLK_BYTES");
      end
   endgenerate

   logic [NQUEUE-1:0] q_alloc, q_svc, q_full, q_set, q_clr;
   logic [NCAUSE-1:0] set_v, clr_v;

   assign q_alloc[CAUSE_MISSQ] = alloc_valid && !kind_queue(alloc_kind);
   assign q_alloc[CAUSE_WBUF]  = alloc_valid &&  kind_queue(alloc_kind);
   assign q_svc[CAUSE_MISSQ]   = mq_service;
   assign q_svc[CAUSE_WBUF]    = wb_service;

   mbc_alloc_path #(
      .AW(AW), .SW(SW), .OW(OW), .BLK_BYTES(BLK_BYTES)
   ) u_alloc (
      .clk(clk), .rst(rst),
      .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
      .alloc_addr(alloc_addr), .alloc_size(alloc_size),
      .alloc_bus_req(alloc_bus_req),
      .ent_valid(ent_valid), .ent_queue(ent_queue),
      .ent_addr(ent_addr), .ent_size(ent_size), .ent_order(ent_order),
      .breq_valid(bus_req), .breq_cause(bus_req_cause)
   );

   generate
      for (genvar q = 0; q < NQUEUE; q++) begin : g_queue
         localparam int QD = (q == 0) ? DEPTH_MQ : DEPTH_WB;
         mbc_queue_occ #(.DEPTH(QD)) u_occ (
            .clk(clk), .rst(rst),
            .alloc(q_alloc[q]), .svc(q_svc[q]),
            .full(q_full[q]), .cause_set(q_set[q]), .cause_clr(q_clr[q])
         );
      end
   endgenerate

   assign set_v = {tgt_set, q_set};
   assign clr_v = {tgt_clr, q_clr};

   mbc_block_mask #(.NC(NCAUSE), .CW(CW)) u_mask (
      .clk(clk), .rst(rst),
      .set_v(set_v), .clr_v(clr_v),
      .mask_q(blk_mask), .stall_q(cpu_stall),
      .ev_flat(blk_events), .cyc_flat(blk_cycles)
   );

   // R5
   missq_mirror_chk: assert property (@(posedge clk) disable iff (rst)
      blk_mask[CAUSE_MISSQ] == q_full[CAUSE_MISSQ]);
   // R6
   wbuf_mirror_chk: assert property (@(posedge clk) disable iff (rst)
      blk_mask[CAUSE_WBUF] == q_full[CAUSE_WBUF]);
endmodule

// File: tb/sim_mbuf_block_ctrl.sv
module sim_mbuf_block_ctrl;
   localparam int PERIOD = 10;
   localparam int AW = 32, SW = 8, OW = 16, CW = 32, BLK = 64;

   logic clk = 1'b0, rst = 1'b1;
   logic alloc_valid = 1'b0, alloc_bus_req = 1'b0;
   logic [1:0] alloc_kind = '0;
   logic [AW-1:0] alloc_addr = '0;
   logic [SW-1:0] alloc_size = '0;
   logic mq_service = 1'b0, wb_service = 1'b0, tgt_set = 1'b0, tgt_clr = 1'b0;
   logic ent_valid, ent_queue, bus_req, bus_req_cause, cpu_stall;
   logic [AW-1:0] ent_addr;
   logic [SW-1:0] ent_size;
   logic [OW-1:0] ent_order;
   logic [2:0] blk_mask;
   logic [3*CW-1:0] blk_events, blk_cycles;

   mbuf_block_ctrl #(.AW(AW), .SW(SW), .OW(OW), .CW(CW), .BLK_BYTES(BLK),
                     .DEPTH_MQ(4), .DEPTH_WB(4)) u0 (
      .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
      .alloc_addr(alloc_addr), .alloc_size(alloc_size), .alloc_bus_req(alloc_bus_req),
      .mq_service(mq_service), .wb_service(wb_service), .tgt_set(tgt_set), .tgt_clr(tgt_clr),
      .ent_valid(ent_valid), .ent_queue(ent_queue), .ent_addr(ent_addr), .ent_size(ent_size),
      .ent_order(ent_order), .bus_req(bus_req), .bus_req_cause(bus_req_cause),
      .cpu_stall(cpu_stall), .blk_mask(blk_mask), .blk_events(blk_events), .blk_cycles(blk_cycles)
   );

   always #(PERIOD/2) clk = ~clk;

   typedef struct packed {
      logic          q;
      logic [AW-1:0] a;
      logic [SW-1:0] s;
      logic [OW-1:0] o;
      logic          b;
   } exp_t;

   exp_t sb[$];
   exp_t mon_e;
   int checks = 0, errors = 0, run = 0;
   logic prev_st = 1'b0;
   logic [OW-1:0] next_ord = '0;
   bit done = 0;
   logic [CW-1:0] exp_c2;

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [CW-1:0] ev(input int c);
      return blk_events[c*CW +: CW];
   endfunction
   function automatic logic [CW-1:0] cy(input int c);
      return blk_cycles[c*CW +: CW];
   endfunction

   // monitor: pops expected entries and measures stall run lengths
   always @(negedge clk) begin
      if (!rst) begin
         if (cpu_stall) begin
            if (!prev_st) run = 1;
            else          run = run + 1;
         end
         prev_st = cpu_stall;
         if (ent_valid) begin
            if (sb.size() == 0) begin
               checks++; errors++;
               $display("FAIL R2 unexpected entry actual=1 expected=0");
            end else begin
               mon_e = sb.pop_front();
               chk("R2", "queue", 64'(ent_queue), 64'(mon_e.q));
               chk("R2", "addr", 64'(ent_addr), 64'(mon_e.a));
               chk("R2", "size", 64'(ent_size), 64'(mon_e.s));
               chk("R3", "order", 64'(ent_order), 64'(mon_e.o));
               chk("R4", "bus_req", 64'(bus_req), 64'(mon_e.b));
               if (mon_e.b) chk("R4", "bus cause", 64'(bus_req_cause), 64'(mon_e.q));
            end
         end else begin
            chk("R4", "idle bus_req", 64'(bus_req), 64'd0);
         end
      end else begin
         prev_st = 1'b0;
      end
   end

   // driver: one allocation, expected entry pushed to the scoreboard
   task automatic do_alloc(input logic [1:0] kind, input logic [AW-1:0] addr,
                           input logic [SW-1:0] size, input logic bus);
      exp_t e;
      e.q = kind[1];
      e.a = (kind == 2'd0) ? (addr & ~AW'(BLK - 1)) : addr;
      e.s = (kind == 2'd0) ? SW'(BLK) : size;
      e.o = next_ord;
      e.b = bus;
      next_ord = next_ord + OW'(1);
      sb.push_back(e);
      alloc_valid = 1'b1; alloc_kind = kind; alloc_addr = addr;
      alloc_size = size; alloc_bus_req = bus;
      @(negedge clk);
      alloc_valid = 1'b0; alloc_bus_req = 1'b0;
   endtask

   task automatic step(input logic ms, input logic ws, input logic ts, input logic tc);
      mq_service = ms; wb_service = ws; tgt_set = ts; tgt_clr = tc;
      @(negedge clk);
      mq_service = 1'b0; wb_service = 1'b0; tgt_set = 1'b0; tgt_clr = 1'b0;
   endtask

   initial begin
      #(PERIOD * 200000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      if (!done) $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "mask", 64'(blk_mask), 64'd0);
      chk("R1", "stall", 64'(cpu_stall), 64'd0);
      chk("R1", "ent_valid", 64'(ent_valid), 64'd0);
      chk("R1", "events", 64'(blk_events[63:0]) | 64'(blk_events[95:64]), 64'd0);
      rst = 1'b0;

      do_alloc(2'd0, 32'h1234_567F, 8'd3, 1'b1);
      do_alloc(2'd1, 32'h0000_1003, 8'd8, 1'b0);
      do_alloc(2'd2, 32'h0000_2005, 8'd4, 1'b1);
      chk("R5", "mask at occ 2", 64'(blk_mask), 64'd0);
      do_alloc(2'd0, 32'h0000_0040, 8'd1, 1'b0);
      chk("R5", "mask at occ 3", 64'(blk_mask), 64'd0);
      do_alloc(2'd0, 32'h0000_07FF, 8'd2, 1'b1);
      chk("R5", "miss queue full bit", 64'(blk_mask), 64'd1);
      chk("R8", "stall on block", 64'(cpu_stall), 64'd1);
      chk("R9", "event cause0", 64'(ev(0)), 64'd1);

      step(1'b0, 1'b0, 1'b1, 1'b0);
      chk("R7", "target bit set", 64'(blk_mask), 64'd5);
      chk("R9", "no event while blocked", 64'(ev(2)), 64'd0);
      step(1'b0, 1'b1, 1'b0, 1'b0);
      chk("R6", "svc non-full wb", 64'(blk_mask), 64'd5);
      step(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R6", "svc full mq clears", 64'(blk_mask), 64'd4);
      chk("R10", "no charge while blocked", 64'(cy(0)), 64'd0);
      step(1'b0, 1'b0, 1'b0, 1'b1);
      chk("R8", "stall released", 64'(cpu_stall), 64'd0);
      chk("R10", "run length", 64'(run), 64'd4);
      chk("R10", "charged to cause2", 64'(cy(2)), 64'(run));
      chk("R10", "cause0 not charged", 64'(cy(0)), 64'd0);
      exp_c2 = cy(2);

      step(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R6", "svc non-full mq idle", 64'(blk_mask), 64'd0);
      step(1'b0, 1'b0, 1'b0, 1'b1);
      chk("R11", "redundant clr stall", 64'(cpu_stall), 64'd0);
      chk("R11", "redundant clr cycles", 64'(cy(2)), 64'(exp_c2));

      step(1'b0, 1'b0, 1'b1, 1'b0);
      chk("R9", "event cause2", 64'(ev(2)), 64'd1);
      step(1'b0, 1'b0, 1'b1, 1'b0);
      chk("R11", "redundant set events", 64'(ev(2)), 64'd1);
      chk("R11", "redundant set stall", 64'(cpu_stall), 64'd1);
      step(1'b0, 1'b0, 1'b1, 1'b1);
      chk("R7", "set wins", 64'(blk_mask), 64'd4);
      step(1'b0, 1'b0, 1'b0, 1'b1);
      chk("R10", "second run", 64'(run), 64'd3);
      chk("R10", "accumulated cause2", 64'(cy(2)), 64'(exp_c2 + CW'(3)));
      exp_c2 = cy(2);

      do_alloc(2'd2, 32'h0000_3001, 8'd1, 1'b0);
      do_alloc(2'd3, 32'h0000_3002, 8'd2, 1'b1);
      do_alloc(2'd2, 32'h0000_3003, 8'd3, 1'b0);
      chk("R5", "wb at occ 3", 64'(blk_mask), 64'd0);
      tgt_set = 1'b1;
      do_alloc(2'd2, 32'h0000_3004, 8'd4, 1'b1);
      tgt_set = 1'b0;
      chk("R5", "wb full and target", 64'(blk_mask), 64'd6);
      chk("R9", "lowest cause event", 64'(ev(1)), 64'd1);
      chk("R9", "cause2 unchanged", 64'(ev(2)), 64'd1);
      step(1'b0, 1'b1, 1'b0, 1'b1);
      chk("R8", "joint release", 64'(cpu_stall), 64'd0);
      chk("R10", "lowest cause charged", 64'(cy(1)), 64'd1);
      chk("R10", "cause2 not charged", 64'(cy(2)), 64'(exp_c2));

      @(negedge clk);
      chk("R2", "scoreboard drained", 64'(sb.size()), 64'd0);

      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "counters cleared", 64'(ev(0)) | 64'(ev(1)) | 64'(cy(1)) | 64'(cy(2)), 64'd0);
      chk("R1", "mask cleared", 64'(blk_mask), 64'd0);
      rst = 1'b0;
      next_ord = '0;
      do_alloc(2'd1, 32'h0000_ABCD, 8'd16, 1'b0);
      @(negedge clk);
      chk("R1", "order restarted", 64'(sb.size()), 64'd0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule